// File: doc/BRIEF.md
# Write-Only Serial Configuration Slave

This block is a two-wire serial bus slave that only accepts writes. It fills a bank of six 8-bit configuration registers for a clock generator. A fast system clock samples the bus clock (SCL) and data (SDA) lines. The block finds START and STOP conditions, checks the address byte, and acknowledges every accepted byte by pulling SDA low.

Every transfer is a block write. Two header bytes follow the address: a command code and a byte count. The block acknowledges both and keeps neither. The payload bytes that follow fill the registers from index 0 upward. The master may end the transfer with STOP after any complete byte. The registers drive parallel outputs and cannot be read back over the bus.

The open-drain pad sits outside the block. The block takes the resolved line level on `sdaIn` and asks for a low level on `sdaOe`.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, `regsOut` equals 48'h00_07_06_FE_FF_16. Register n occupies bits [8n+7:8n], so register 0 = 0x16, 1 = 0xFF, 2 = 0xFE, 3 = 0x06, 4 = 0x07 and 5 = 0x00.
- R2: An address byte of 0xD2 (7-bit address 0x69, R/W bit = 0) is acknowledged: `sdaOe` is high during the ninth SCL pulse.
- R3: Any other address byte, including 0xD3 (R/W = 1), is not acknowledged. After it, no byte is acknowledged and no register changes until the next START.
- R4: The first two bytes after an accepted address (the command code and the byte count) are each acknowledged and leave every register unchanged.
- R5: Payload bytes are written to register 0, 1, 2 and so on in the order received, and each one is acknowledged.
- R6: After a STOP that follows any complete payload byte, the registers already written keep their new values and the others keep their old values.
- R7: Payload bytes beyond register 5 are acknowledged and discarded. The write index never wraps back to register 0.
- R8: A repeated START restarts the address phase, and the following payload begins again at register 0.
- R9: `sdaOe` is asserted only while SCL is low, and only in the acknowledge slot. It is never high while the master clocks a data bit.
- R10: `sdaOe` is low whenever the slave is idle, including after reset and after STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Resolved bus data line level |
| sdaOe | output | 1 | High to pull the data line low (acknowledge) |
| regsOut | output | 48 | Configuration registers; register n at bits [8n+7:8n] |

## Verification
Two events can fall in the same sampling cycle. One is the SCL falling edge that closes a payload byte: in that cycle the block both writes a register and begins driving the acknowledge. The other is a START that arrives while a payload index is still pending. The bench exercises both with a repeated START immediately after a payload acknowledge. It then checks that the next payload lands in register 0, and that the bytes written before the restart survive. A bound property separately checks that a START strobe always clears the write index on the following cycle.

// File: rtl/cfg_i2c_pkg.sv
`timescale 1ns/1ps
package cfg_i2c_pkg;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic clrIdx;
    logic wrEn;
  } cfgStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_ACK  = 2'd2
  } busState_t;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_CMD  = 2'd1,
    PH_CNT  = 2'd2,
    PH_DATA = 2'd3
  } bytePhase_t;

endpackage

// File: rtl/cfg_i2c_ctrl.sv
`timescale 1ns/1ps
module cfg_i2c_ctrl
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  output cfgStrobe_t strb,
  output logic       sdaOe,
  output logic       busy
);

  localparam logic [7:0] ADDR_W = {DEV_ADDR, 1'b0};

  logic sclMeta, sclS, sclD;
  logic sdaMeta, sdaS, sdaD;
  logic startDet, stopDet, sclRise, sclFall;
  logic [3:0] bitCnt;
  logic byteFull;
  busState_t state;
  bytePhase_t phase;

  // SCL and SDA go through identical two-flop paths so their relative order is kept
  assign startDet = sclS && sclD && sdaD && !sdaS;
  assign stopDet  = sclS && sclD && !sdaD && sdaS;
  assign sclRise  = sclS && !sclD;
  assign sclFall  = !sclS && sclD;
  assign byteFull = (bitCnt == 4'd8);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 1'b1;
      sclS    <= 1'b1;
      sclD    <= 1'b1;
      sdaMeta <= 1'b1;
      sdaS    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclMeta <= sclIn;
      sclS    <= sclMeta;
      sclD    <= sclS;
      sdaMeta <= sdaIn;
      sdaS    <= sdaMeta;
      sdaD    <= sdaS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_ADDR;
      bitCnt <= 4'd0;
      sdaOe  <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else if (startDet) begin
      state  <= ST_RECV;
      phase  <= PH_ADDR;
      bitCnt <= 4'd0;
      sdaOe  <= 1'b0;
    end else begin
      case (state)
        ST_RECV: begin
          if (sclRise && !byteFull) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall && byteFull) begin
            if (phase == PH_ADDR && rxByte != ADDR_W) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_ACK;
              sdaOe <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            sdaOe  <= 1'b0;
            state  <= ST_RECV;
            bitCnt <= 4'd0;
            if (phase != PH_DATA) phase <= bytePhase_t'(phase + 2'd1);
          end
        end
        default: begin
          state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.shiftBit = sdaS;
    strb.shiftEn  = (state == ST_RECV) && sclRise && !byteFull;
    strb.clrIdx   = startDet && !stopDet;
    strb.wrEn     = (state == ST_RECV) && sclFall && byteFull &&
                    (phase == PH_DATA) && !startDet && !stopDet;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/cfg_i2c_regs.sv
`timescale 1ns/1ps
module cfg_i2c_regs
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 6,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = 48'h00_07_06_FE_FF_16,
  localparam int IDX_W = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobe_t            strb,
  output logic [7:0]            rxByte,
  output logic [IDX_W-1:0]      regIdx,
  output logic [NUM_REGS*8-1:0] regsOut
);

  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_REGS);

  logic [7:0] shifter;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shifter <= 8'd0;
    else if (strb.shiftEn) shifter <= {shifter[6:0], strb.shiftBit};
  end

  assign rxByte = shifter;

  // Index saturates at IDX_END: surplus payload is dropped, never wrapped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regIdx <= '0;
    else if (strb.clrIdx) regIdx <= '0;
    else if (strb.wrEn && regIdx < IDX_END) regIdx <= regIdx + 1'b1;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gBank
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= RESET_VAL[g*8 +: 8];
      else if (strb.wrEn && regIdx == IDX_W'(g)) q <= shifter;
    end
    assign regsOut[g*8 +: 8] = q;
  end

endmodule

// File: rtl/cfg_i2c_slave.sv
`timescale 1ns/1ps
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 6,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = 48'h00_07_06_FE_FF_16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regsOut
);

  localparam int IDX_W = $clog2(NUM_REGS + 1);

  cfgStrobe_t       strb;
  logic [7:0]       rxByte;
  logic [IDX_W-1:0] regIdx;
  logic             busy;

  cfg_i2c_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .rxByte (rxByte),
    .strb   (strb),
    .sdaOe  (sdaOe),
    .busy   (busy)
  );

  cfg_i2c_regs #(.NUM_REGS(NUM_REGS), .RESET_VAL(RESET_VAL)) regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rxByte  (rxByte),
    .regIdx  (regIdx),
    .regsOut (regsOut)
  );

endmodule

// File: rtl/cfg_i2c_chk.sv
`timescale 1ns/1ps
module cfg_i2c_chk
  import cfg_i2c_pkg::*;
#(
  parameter int NUM_REGS = 6,
  localparam int IDX_W = $clog2(NUM_REGS + 1)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic [NUM_REGS*8-1:0] regsOut,
  input cfgStrobe_t            strb,
  input logic [IDX_W-1:0]      regIdx,
  input logic                  busy
);

  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_REGS);

  AST_ACK_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclIn, 3)); // R9

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> $stable(regsOut)); // R4

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.clrIdx && regIdx < IDX_END) |=> (regIdx == IDX_W'($past(regIdx) + 1'b1))); // R5

  AST_IDX_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (regIdx == IDX_END && !strb.clrIdx) |=> (regIdx == IDX_END)); // R7

  AST_START_CLEARS_IDX: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrIdx |=> (regIdx == '0)); // R8

  AST_NO_OE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sdaOe); // R10

endmodule

bind cfg_i2c_slave cfg_i2c_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .sclIn   (sclIn),
  .sdaOe   (sdaOe),
  .regsOut (regsOut),
  .strb    (strb),
  .regIdx  (regIdx),
  .busy    (busy)
);

// File: tb/cfg_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module cfg_i2c_slave_tb_top;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic dutOe;
  logic [47:0] regsOut;

  int checks = 0;
  int failures = 0;
  logic oeBad = 1'b0;
  logic [7:0] expReg [6];

  always #4 clk = ~clk;

  assign sdaBus = sdaM & ~dutOe;

  cfg_i2c_slave dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclM),
    .sdaIn   (sdaBus),
    .sdaOe   (dutOe),
    .regsOut (regsOut)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkRegs(input string req);
    logic [47:0] e;
    for (int i = 0; i < 6; i++) e[i*8 +: 8] = expReg[i];
    chk(regsOut == e, req, {16'd0, regsOut}, {16'd0, e});
  endtask

  task automatic qwait;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic busStart;
    sdaM = 1'b1; qwait;
    sclM = 1'b1; qwait;
    sdaM = 1'b0; qwait;
    sclM = 1'b0; qwait;
  endtask

  task automatic busStop;
    sdaM = 1'b0; qwait;
    sclM = 1'b1; qwait;
    sdaM = 1'b1; qwait;
    qwait;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; qwait;
      sclM = 1'b1; qwait;
      if (dutOe) oeBad = 1'b1;
      qwait;
      sclM = 1'b0; qwait;
    end
    sdaM = 1'b1; qwait;
    sclM = 1'b1; qwait;
    acked = !sdaBus;
    qwait;
    sclM = 1'b0; qwait;
  endtask

  task automatic testReset;
    expReg[0] = 8'h16; expReg[1] = 8'hFF; expReg[2] = 8'hFE;
    expReg[3] = 8'h06; expReg[4] = 8'h07; expReg[5] = 8'h00;
    chkRegs("R1 reset defaults");
    chk(dutOe == 1'b0, "R10 idle after reset", {63'd0, dutOe}, 64'd0);
  endtask

  task automatic testFullWrite;
    logic a;
    busStart;
    sendByte(8'hD2, a); chk(a, "R2 address ack", {63'd0, a}, 64'd1);
    sendByte(8'h5A, a); chk(a, "R4 command ack", {63'd0, a}, 64'd1);
    sendByte(8'h06, a); chk(a, "R4 count ack", {63'd0, a}, 64'd1);
    for (int i = 0; i < 6; i++) begin
      sendByte(8'h11 * (i + 1), a);
      chk(a, "R5 payload ack", {63'd0, a}, 64'd1);
      expReg[i] = 8'h11 * (i + 1);
    end
    busStop;
    chkRegs("R5 ascending fill");
    chk(oeBad == 1'b0, "R9 no drive in data bits", {63'd0, oeBad}, 64'd0);
    chk(dutOe == 1'b0, "R10 idle after stop", {63'd0, dutOe}, 64'd0);
  endtask

  task automatic testHeaderOnly;
    logic a;
    busStart;
    sendByte(8'hD2, a);
    sendByte(8'hAB, a); chk(a, "R4 command ack", {63'd0, a}, 64'd1);
    sendByte(8'hCD, a); chk(a, "R4 count ack", {63'd0, a}, 64'd1);
    busStop;
    chkRegs("R4 header bytes ignored");
  endtask

  task automatic testPartial;
    logic a;
    busStart;
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h02, a);
    sendByte(8'hA1, a); sendByte(8'hA2, a);
    busStop;
    expReg[0] = 8'hA1; expReg[1] = 8'hA2;
    chkRegs("R6 partial write keeps rest");
  endtask

  task automatic testOverflow;
    logic a;
    logic allAck;
    allAck = 1'b1;
    busStart;
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h08, a);
    for (int i = 0; i < 8; i++) begin
      sendByte(8'h80 + 8'(i), a);
      allAck = allAck & a;
      if (i < 6) expReg[i] = 8'h80 + 8'(i);
    end
    busStop;
    chk(allAck, "R7 surplus bytes acked", {63'd0, allAck}, 64'd1);
    chkRegs("R7 no wrap");
  endtask

  task automatic testBadAddr(input logic [7:0] adr);
    logic a;
    logic anyAck;
    busStart;
    sendByte(adr, a);
    chk(!a, "R3 foreign address nack", {63'd0, a}, 64'd0);
    anyAck = 1'b0;
    sendByte(8'h00, a); anyAck = anyAck | a;
    sendByte(8'h01, a); anyAck = anyAck | a;
    sendByte(8'h3C, a); anyAck = anyAck | a;
    busStop;
    chk(!anyAck, "R3 bus ignored after nack", {63'd0, anyAck}, 64'd0);
    chkRegs("R3 registers unchanged");
  endtask

  task automatic testRestart;
    logic a;
    busStart;
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h02, a);
    sendByte(8'hC1, a); sendByte(8'hC2, a);
    busStart;
    sendByte(8'hD2, a); chk(a, "R8 address after restart", {63'd0, a}, 64'd1);
    sendByte(8'h00, a); sendByte(8'h01, a);
    sendByte(8'hE1, a);
    busStop;
    expReg[0] = 8'hE1; expReg[1] = 8'hC2;
    chkRegs("R8 restart rewinds index");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (10) @(posedge clk);
    #1 rstN = 1'b1;
    qwait;
    testReset;
    testFullWrite;
    testHeaderOnly;
    testPartial;
    testOverflow;
    testBadAddr(8'hD4);
    testBadAddr(8'hD3);
    testRestart;
    chk(oeBad == 1'b0, "R9 no drive in data bits", {63'd0, oeBad}, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule